// File: doc/BRIEF.md
# Host-Port Program Loader

After reset, this block copies a program image from a byte-wide host channel into a program memory that is 24 bits wide. The block samples a four-bit strap value on its mode pins while reset is held. The value that is present on the last reset cycle sets the course of the block. If the two upper strap bits are both one, the block boots from the host port. The two lower bits are then reported as the host bus flavour, which the host interface logic uses. For any other strap value the block stays quiet and reports that it was not selected.

Once host boot is selected, the block takes bytes over a valid/ready handshake. Every 24-bit quantity arrives as three bytes, least significant byte first. The first three bytes give the number of words to load. The next three bytes give the load address. Each program word that follows is written to the load address plus its index. After the last word has been written, the block raises a sticky done flag and presents the load address as the jump target for the core.

Top module: `boot_loader`

## Requirements
- R1: The block captures the strap pins `mode_pins` on every cycle in which `rst` is high. `bus_sel` shows bits [1:0] of the value captured on the final reset cycle, and later changes on the pins have no effect on it.
- R2: If strap bits [3:2] are not `2'b11`, the block raises `not_selected` and holds `byte_ready`, `busy`, `mem_we` and `done` low, so that no byte is ever consumed.
- R3: With host boot selected, the first three accepted bytes form the 24-bit word count, least significant byte first. A byte is accepted on a rising edge where `byte_valid` and `byte_ready` are both high.
- R4: The next three accepted bytes form the 24-bit load address, least significant byte first.
- R5: Each program word is assembled from three bytes, least significant byte first. Word k (counting from 0) is written at address load address + k, modulo 2^24.
- R6: Each assembled word produces `mem_we` for exactly one cycle, with `mem_addr` and `mem_data` valid in that cycle. `byte_ready` stays low from the third byte of a word until that write has been issued.
- R7: After the number of words given by the count has been written, `done` goes high and stays high until reset, `busy` goes low, and `jump_addr` equals the load address.
- R8: If the word count is zero, `done` goes high right after the address header and no write takes place.
- R9: Directly after reset with host boot selected, `busy` and `byte_ready` are high, and `done`, `not_selected` and `mem_we` are low.
- R10: Once `done` is high, `byte_ready` stays low, and any bytes offered cause no write and do not change `jump_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_pins | input | 4 | Strap value, sampled during reset |
| byte_data | input | 8 | Incoming host byte |
| byte_valid | input | 1 | Host byte present |
| byte_ready | output | 1 | Loader can take a byte |
| mem_addr | output | 24 | Program memory write address |
| mem_data | output | 24 | Program memory write data |
| mem_we | output | 1 | Single-cycle write strobe |
| bus_sel | output | 2 | Latched host bus flavour |
| not_selected | output | 1 | Strap value does not select host boot |
| busy | output | 1 | Loading is in progress |
| done | output | 1 | Loading finished (sticky) |
| jump_addr | output | 24 | Start address to jump to once done |

## Verification
A byte counter that slips by one position shows up on the first write. The address and data on the write port then come out rotated by a byte, and the write arrives a byte early or late. A wrong word index shows up as an address that does not step by one between strobes, or as `done` rising one write too early or too late. The scoreboard compares every strobe against the expected address and data on the cycle in which the strobe occurs. It also counts the strobes when `done` rises, so a count mismatch is reported at the end of that load. A state machine that leaves the done or idle state is caught by the first byte offered afterwards, because that byte would raise `byte_ready` or produce a write.

// File: rtl/boot_loader.sv
module boot_loader #(
  parameter int WORD_W = 24,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        mode_pins,
  input  logic [BYTE_W-1:0] byte_data,
  input  logic              byte_valid,
  output logic              byte_ready,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              mem_we,
  output logic [1:0]        bus_sel,
  output logic              not_selected,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] jump_addr
);
  localparam int LOW_W = WORD_W - BYTE_W;
  localparam int NBYTE = WORD_W / BYTE_W;

  typedef enum logic [2:0] {S_CNT, S_ADR, S_DAT, S_WR, S_DONE, S_OFF} state_t;

  state_t            st;
  logic [1:0]        bus_q;
  logic [LOW_W-1:0]  sh;
  logic [1:0]        bidx;
  logic [WORD_W-1:0] cnt, base, idx, wdata;

  wire              take    = byte_valid && byte_ready;
  wire              last    = (bidx == 2'(NBYTE - 1));
  wire [WORD_W-1:0] word    = {byte_data, sh};
  wire [WORD_W-1:0] idx_nxt = idx + 1'b1;

  assign byte_ready   = (st == S_CNT) || (st == S_ADR) || (st == S_DAT);
  assign busy         = byte_ready || (st == S_WR);
  assign done         = (st == S_DONE);
  assign not_selected = (st == S_OFF);
  assign mem_we       = (st == S_WR);
  assign mem_addr     = base + idx;
  assign mem_data     = wdata;
  assign bus_sel      = bus_q;
  assign jump_addr    = done ? base : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_q <= mode_pins[1:0];
      st    <= (mode_pins[3:2] == 2'b11) ? S_CNT : S_OFF;
      sh    <= '0;
      bidx  <= '0;
      cnt   <= '0;
      base  <= '0;
      idx   <= '0;
      wdata <= '0;
    end else begin
      if (take) begin
        sh   <= word[WORD_W-1:BYTE_W];
        bidx <= last ? 2'd0 : bidx + 2'd1;
      end
      case (st)
        S_CNT: if (take && last) begin
          cnt <= word;
          st  <= S_ADR;
        end
        S_ADR: if (take && last) begin
          base <= word;
          idx  <= '0;
          st   <= (cnt == '0) ? S_DONE : S_DAT;
        end
        S_DAT: if (take && last) begin
          wdata <= word;
          st    <= S_WR;
        end
        S_WR: begin
          idx <= idx_nxt;
          st  <= (idx_nxt == cnt) ? S_DONE : S_DAT;
        end
        default: st <= st;
      endcase
    end
  end
endmodule

module boot_loader_chk (
  input logic        clk,
  input logic        rst,
  input logic        byte_ready,
  input logic        mem_we,
  input logic [23:0] mem_addr,
  input logic [1:0]  bus_sel,
  input logic        not_selected,
  input logic        busy,
  input logic        done,
  input logic [23:0] jump_addr
);
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst) mem_we |=> !mem_we); // R6
  AST_NO_READY_IN_WRITE: assert property (@(posedge clk) disable iff (rst) mem_we |-> !byte_ready); // R6
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) done |=> done && $stable(jump_addr)); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst) done |-> !busy && !byte_ready && !mem_we); // R10
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst) not_selected |-> !byte_ready && !busy && !mem_we && !done); // R2
  AST_BUS_HELD: assert property (@(posedge clk) disable iff (rst) !$rose(rst) |-> $stable(bus_sel)); // R1
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) mem_we |=> $stable(mem_addr) || mem_addr == $past(mem_addr) + 24'd1); // R5
endmodule

bind boot_loader boot_loader_chk chk_i (
  .clk(clk), .rst(rst), .byte_ready(byte_ready), .mem_we(mem_we),
  .mem_addr(mem_addr), .bus_sel(bus_sel), .not_selected(not_selected),
  .busy(busy), .done(done), .jump_addr(jump_addr)
);

// File: tb/boot_loader_tb.sv
module boot_loader_tb_top;
  logic        clk = 0;
  logic        rst = 1;
  logic [3:0]  mode_pins = 4'b1100;
  logic [7:0]  byte_data = 0;
  logic        byte_valid = 0;
  logic        byte_ready, mem_we, not_selected, busy, done;
  logic [23:0] mem_addr, mem_data, jump_addr;
  logic [1:0]  bus_sel;

  int tests = 0, fails = 0, writes = 0;
  logic [47:0] exp_q[$];

  always #2 clk = ~clk;

  boot_loader dut_i (
    .clk(clk), .rst(rst), .mode_pins(mode_pins), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_we(mem_we), .bus_sel(bus_sel),
    .not_selected(not_selected), .busy(busy), .done(done), .jump_addr(jump_addr)
  );

  task automatic check(string req, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every write strobe is compared with the scoreboard head
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      writes++;
      check("R6 ready low during write", {47'd0, byte_ready}, 48'd0);
      if (exp_q.size() == 0) check("R5/R10 unexpected write", {mem_addr, mem_data}, 48'hxxxx);
      else check("R5 write addr/data", {mem_addr, mem_data}, exp_q.pop_front());
    end
  end

  task automatic do_reset(logic [3:0] m);
    @(negedge clk);
    rst = 1; mode_pins = m; byte_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    writes = 0;
  endtask

  task automatic send_byte(logic [7:0] b);
    byte_data = b; byte_valid = 1;
    while (!byte_ready) @(negedge clk);
    @(negedge clk);
    byte_valid = 0;
  endtask

  task automatic send24(logic [23:0] v);
    for (int i = 0; i < 3; i++) send_byte(v[8*i +: 8]);
  endtask

  task automatic load(logic [23:0] base, int n, logic [23:0] seed);
    send24(24'(n));
    send24(base);
    for (int k = 0; k < n; k++) begin
      logic [23:0] w = seed ^ (24'(k) * 24'h010203);
      exp_q.push_back({base + 24'(k), w});
      send24(w);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    fork
      begin repeat (100000) @(posedge clk); fails++; tests++;
        $display("FAIL watchdog expired"); $display("[TB] %0d tests run, %0d failed", tests, fails); $finish; end
    join_none

    // R9 reset state, R1 latch
    do_reset(4'b1101);
    check("R9 busy/ready/done/nsel/we", {43'd0, busy, byte_ready, done, not_selected, mem_we}, {43'd0, 5'b11000});
    check("R1 bus_sel", {46'd0, bus_sel}, 48'd1);
    mode_pins = 4'b0010;
    repeat (2) @(negedge clk);
    check("R1 bus_sel held after pin change", {46'd0, bus_sel}, 48'd1);

    // R3 R4 R5 R7 normal load
    do_reset(4'b1100);
    load(24'h001000, 3, 24'hA1B2C3);
    check("R7 done", {47'd0, done}, 48'd1);
    check("R7 busy low", {47'd0, busy}, 48'd0);
    check("R7 jump_addr", {24'd0, jump_addr}, {24'd0, 24'h001000});
    check("R3 write count", 48'(writes), 48'd3);
    check("R5 scoreboard empty", 48'(exp_q.size()), 48'd0);

    // R10 bytes after done ignored
    byte_data = 8'h55; byte_valid = 1;
    repeat (5) @(negedge clk);
    byte_valid = 0;
    check("R10 ready low after done", {47'd0, byte_ready}, 48'd0);
    check("R10 no write, done kept", {46'd0, done, 1'b0}, {46'd0, 2'b10});
    check("R10 jump_addr unchanged", {24'd0, jump_addr}, {24'd0, 24'h001000});
    check("R10 write count", 48'(writes), 48'd3);

    // R8 zero count
    do_reset(4'b1110);
    check("R1 bus_sel 10", {46'd0, bus_sel}, 48'd2);
    send24(24'd0);
    send24(24'hABCDEF);
    @(negedge clk);
    check("R8 done after header", {47'd0, done}, 48'd1);
    check("R8 jump_addr", {24'd0, jump_addr}, {24'd0, 24'hABCDEF});
    check("R8 no writes", 48'(writes), 48'd0);

    // R5 address wrap, single words at top of space
    do_reset(4'b1111);
    load(24'hFFFFFE, 4, 24'h123456);
    check("R5 wrap writes", 48'(writes), 48'd4);
    check("R7 jump after wrap", {23'd0, done, jump_addr}, {23'd0, 1'b1, 24'hFFFFFE});

    // R2 not selected
    do_reset(4'b0111);
    byte_data = 8'h01; byte_valid = 1;
    repeat (6) @(negedge clk);
    byte_valid = 0;
    check("R2 quiet outputs", {43'd0, not_selected, byte_ready, busy, mem_we, done}, {43'd0, 5'b10000});
    check("R2 no writes", 48'(writes), 48'd0);
    do_reset(4'b1000);
    check("R2 mode 1000 not selected", {47'd0, not_selected}, 48'd1);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule